// File: doc/BRIEF.md
# SPI NOR Flash Command Sequencer

This block sits between a client that thinks in flash operations and a single-lane serial NOR flash device. The client presents one request at a time. Each request carries an operation code, a 24-bit byte address and a byte count. The block turns the request into one or more chip-select-framed serial transactions and pulses `done` when the whole operation has finished.

Program and erase requests are expanded automatically. The block first sends a stand-alone write-enable transaction, then the operation itself. It then polls the status register in separate transactions until the device reports that it is idle. Only then does it signal completion. Program data enters on a byte-wide valid/ready stream. Identification and read data leave on a second byte-wide valid/ready stream. When the consumer stalls, the serial clock pauses between bytes instead of dropping data.

The serial side uses clock polarity 0 and phase 0. The clock idles low, the device samples on the rising edge and the outgoing bit changes on the falling edge. Every byte goes out most significant bit first.

Top module: `nor_cmd_seq`

## Requirements
- R1: After a synchronous reset, `spi_cs_n` is 1, `spi_sck` is 0, `req_ready` is 1, and `done`, `err` and `rd_valid` are 0.
- R2: `spi_sck` stays low while `spi_cs_n` is high. `spi_mosi` holds steady while `spi_sck` is high. Every byte is shifted most significant bit first.
- R3: Between two consecutive transactions, `spi_cs_n` stays high for at least two clock cycles.
- R4: `req_op`=0 (identify) sends one transaction. That transaction starts with byte 0x9F and then clocks `req_len` more bytes. Each received byte is delivered on the read stream in order.
- R5: `req_op`=1 (read) sends one transaction: byte 0x03, then the three address bytes with the most significant byte first, then `req_len` clocked bytes. Each of those bytes goes to the read stream in order. With `req_len`=0 the transaction is only the four header bytes.
- R6: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` stays 1 and `rd_data` does not change. No read byte is lost or duplicated under back-pressure.
- R7: `req_op`=2 (program) first sends a one-byte transaction 0x06. It then sends 0x02, the three address bytes with the most significant first, and `req_len` bytes taken from the write stream in order. Status polling (R9) follows.
- R8: `req_op`=3 (64 KB erase) sends 0x06 alone and then 0x02's counterpart 0xD8 followed by the three address bytes. `req_op`=4 (whole-device erase) sends 0x06 alone and then 0xC7 alone. Both then poll as in R9.
- R9: After a program or erase, the block repeats a two-byte transaction: 0x05 followed by one clocked status byte. It repeats while bit 0 of the status byte is 1 and ignores the other bits. `done` comes only after a poll returns bit 0 equal to 0.
- R10: `req_op`=5 sends the single byte 0xB9 and `req_op`=6 sends the single byte 0xAB. Each is one transaction followed by `done`.
- R11: A program request is rejected when the count is 0 or greater than 256, or when (address mod 256) plus the count exceeds 256. A rejected request pulses `err` for one cycle one clock after acceptance, and `spi_cs_n` never goes low for it.
- R12: `req_op`=7 is rejected with a one-cycle `err` pulse, and no transaction is sent.
- R13: `req_ready` is 1 only while no operation is in progress. `done` is a one-cycle pulse that never coincides with `err`. A new request may be accepted in the cycle that `done` is visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when both high |
| req_op | input | 3 | Operation code (0 identify, 1 read, 2 program, 3 64 KB erase, 4 full erase, 5 sleep, 6 wake) |
| req_addr | input | 24 | Byte address |
| req_len | input | LEN_W | Byte count for the data phase |
| wr_valid | input | 1 | Program data byte present |
| wr_ready | output | 1 | Program data byte taken |
| wr_data | input | 8 | Program data byte |
| rd_valid | output | 1 | Read data byte present |
| rd_ready | input | 1 | Consumer takes read data byte |
| rd_data | output | 8 | Read data byte |
| done | output | 1 | One-cycle pulse when an operation has finished |
| err | output | 1 | One-cycle pulse when a request was rejected |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The completion pulse of one operation and the acceptance of the next request can fall in the same cycle. The bench provokes this by presenting each new request right after `done` and running many operations back to back. It then measures the high time of chip select between transactions at every clock and checks that the next transaction's header bytes are intact. A second collision is a read byte finishing while the previous byte is still held by a stalled consumer. A periodic `rd_ready` pattern forces this case, and the bench compares each delivered byte with an address-derived value.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [2:0] {
        OP_IDENT    = 3'd0,
        OP_READ     = 3'd1,
        OP_PROG     = 3'd2,
        OP_ERASE64K = 3'd3,
        OP_ERASEALL = 3'd4,
        OP_SLEEP    = 3'd5,
        OP_WAKE     = 3'd6,
        OP_INVALID  = 3'd7
    } req_op_e;

    typedef enum logic [1:0] {
        DIR_NONE  = 2'd0,
        DIR_WRITE = 2'd1,
        DIR_READ  = 2'd2
    } dir_e;

    typedef enum logic [1:0] {
        PH_WREN = 2'd0,
        PH_MAIN = 2'd1,
        PH_POLL = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GAP  = 2'd1,
        ST_HDR  = 2'd2,
        ST_DATA = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [7:0] opcode;
        logic       with_addr;
        dir_e       dir;
    } txn_plan_t;

    localparam logic [7:0] CMD_WREN   = 8'h06;
    localparam logic [7:0] CMD_STATUS = 8'h05;
    localparam logic [7:0] CMD_IDENT  = 8'h9F;
    localparam logic [7:0] CMD_READ   = 8'h03;
    localparam logic [7:0] CMD_PROG   = 8'h02;
    localparam logic [7:0] CMD_ER64K  = 8'hD8;
    localparam logic [7:0] CMD_ERALL  = 8'hC7;
    localparam logic [7:0] CMD_SLEEP  = 8'hB9;
    localparam logic [7:0] CMD_WAKE   = 8'hAB;

    function automatic txn_plan_t main_plan(req_op_e op);
        txn_plan_t p;
        case (op)
            OP_IDENT:    p = '{opcode: CMD_IDENT, with_addr: 1'b0, dir: DIR_READ};
            OP_READ:     p = '{opcode: CMD_READ,  with_addr: 1'b1, dir: DIR_READ};
            OP_PROG:     p = '{opcode: CMD_PROG,  with_addr: 1'b1, dir: DIR_WRITE};
            OP_ERASE64K: p = '{opcode: CMD_ER64K, with_addr: 1'b1, dir: DIR_NONE};
            OP_ERASEALL: p = '{opcode: CMD_ERALL, with_addr: 1'b0, dir: DIR_NONE};
            OP_SLEEP:    p = '{opcode: CMD_SLEEP, with_addr: 1'b0, dir: DIR_NONE};
            default:     p = '{opcode: CMD_WAKE,  with_addr: 1'b0, dir: DIR_NONE};
        endcase
        return p;
    endfunction

    function automatic logic alters_array(req_op_e op);
        return (op == OP_PROG) || (op == OP_ERASE64K) || (op == OP_ERASEALL);
    endfunction

endpackage

// File: rtl/nor_spi_engine.sv
module nor_spi_engine #(
    parameter int SCK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx,
    output logic       done,
    output logic [7:0] rx,
    output logic       sck,
    output logic       mosi,
    input  logic       miso
);
    localparam int DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCK_HALF - 1);

    logic             active;
    logic             sck_q;
    logic [2:0]       bitn;
    logic [DIV_W-1:0] div;
    logic [7:0]       txs;
    logic [7:0]       rxs;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sck_q  <= 1'b0;
            bitn   <= '0;
            div    <= '0;
            txs    <= '0;
            rxs    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    txs    <= tx;
                    div    <= '0;
                    bitn   <= '0;
                end
            end else if (div == DIV_LAST) begin
                div <= '0;
                if (!sck_q) begin
                    // rising edge: sample the device
                    sck_q <= 1'b1;
                    rxs   <= {rxs[6:0], miso};
                end else begin
                    // falling edge: move to the next outgoing bit
                    sck_q <= 1'b0;
                    if (bitn == 3'd7) begin
                        active <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bitn <= bitn + 1'b1;
                        txs  <= {txs[6:0], 1'b0};
                    end
                end
            end else begin
                div <= div + 1'b1;
            end
        end
    end

    assign done = done_q;
    assign rx   = rxs;
    assign sck  = sck_q;
    assign mosi = txs[7];

endmodule

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
    import nor_seq_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int PAGE_BYTES = 256,
    parameter int CS_GAP     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_op,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic             err,
    output logic             cs_n,
    output logic             eng_start,
    output logic [7:0]       eng_tx,
    input  logic             eng_done,
    input  logic [7:0]       eng_rx
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int SUM_W  = LEN_W + 1;
    localparam int GAP_W  = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(CS_GAP - 1);

    seq_state_e       st;
    phase_e           ph;
    req_op_e          op_q;
    logic [23:0]      addr_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] left;
    logic [1:0]       hidx;
    logic [GAP_W-1:0] gcnt;
    logic             inflight;
    logic             rdv;
    logic [7:0]       rdd;
    logic             done_q;
    logic             err_q;
    logic             dev_busy;

    txn_plan_t  cur;
    logic [7:0] hdr_byte;
    logic [1:0] hdr_last;
    logic       hdr_go, wr_go, rd_go, txn_end;
    logic       prog_fits, reject;
    logic [SUM_W-1:0] page_end;

    always_comb begin
        case (ph)
            PH_WREN: cur = '{opcode: CMD_WREN,   with_addr: 1'b0, dir: DIR_NONE};
            PH_POLL: cur = '{opcode: CMD_STATUS, with_addr: 1'b0, dir: DIR_READ};
            default: cur = main_plan(op_q);
        endcase
        case (hidx)
            2'd0:    hdr_byte = cur.opcode;
            2'd1:    hdr_byte = addr_q[23:16];
            2'd2:    hdr_byte = addr_q[15:8];
            default: hdr_byte = addr_q[7:0];
        endcase
        hdr_last = cur.with_addr ? 2'd3 : 2'd0;
    end

    assign page_end  = SUM_W'(req_addr[PAGE_W-1:0]) + SUM_W'(req_len);
    assign prog_fits = (req_len != '0) && (page_end <= SUM_W'(PAGE_BYTES));
    assign reject    = (req_op == OP_INVALID) || ((req_op == OP_PROG) && !prog_fits);

    assign hdr_go  = (st == ST_HDR) && !inflight;
    assign wr_go   = (st == ST_DATA) && !inflight && (left != '0)
                     && (cur.dir == DIR_WRITE) && wr_valid;
    assign rd_go   = (st == ST_DATA) && !inflight && (left != '0)
                     && (cur.dir == DIR_READ) && !rdv;
    assign txn_end = (st == ST_DATA) && !inflight && (left == '0);

    assign eng_start = hdr_go || wr_go || rd_go;
    assign eng_tx    = hdr_go ? hdr_byte : (wr_go ? wr_data : 8'h00);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            ph       <= PH_MAIN;
            op_q     <= OP_IDENT;
            addr_q   <= '0;
            len_q    <= '0;
            left     <= '0;
            hidx     <= '0;
            gcnt     <= '0;
            inflight <= 1'b0;
            rdv      <= 1'b0;
            rdd      <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            dev_busy <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (rdv && rd_ready) rdv <= 1'b0;
            if (eng_start) inflight <= 1'b1;
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (reject) begin
                            err_q <= 1'b1;
                        end else begin
                            op_q   <= req_op_e'(req_op);
                            addr_q <= req_addr;
                            len_q  <= req_len;
                            ph     <= alters_array(req_op_e'(req_op)) ? PH_WREN : PH_MAIN;
                            gcnt   <= '0;
                            st     <= ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    if (gcnt == GAP_LAST) begin
                        st   <= ST_HDR;
                        hidx <= '0;
                    end else begin
                        gcnt <= gcnt + 1'b1;
                    end
                end
                ST_HDR: begin
                    if (eng_done) begin
                        inflight <= 1'b0;
                        if (hidx == hdr_last) begin
                            st <= ST_DATA;
                            if (cur.dir == DIR_NONE) left <= '0;
                            else if (ph == PH_POLL)  left <= LEN_W'(1);
                            else                     left <= len_q;
                        end else begin
                            hidx <= hidx + 1'b1;
                        end
                    end
                end
                default: begin
                    if (eng_done) begin
                        inflight <= 1'b0;
                        left     <= left - 1'b1;
                        if (ph == PH_POLL) begin
                            dev_busy <= eng_rx[0];
                        end else if (cur.dir == DIR_READ) begin
                            rdv <= 1'b1;
                            rdd <= eng_rx;
                        end
                    end
                    if (txn_end) begin
                        gcnt <= '0;
                        case (ph)
                            PH_WREN: begin
                                ph <= PH_MAIN;
                                st <= ST_GAP;
                            end
                            PH_MAIN: begin
                                if (alters_array(op_q)) begin
                                    ph <= PH_POLL;
                                    st <= ST_GAP;
                                end else begin
                                    st     <= ST_IDLE;
                                    done_q <= 1'b1;
                                end
                            end
                            default: begin
                                if (dev_busy) begin
                                    st <= ST_GAP;
                                end else begin
                                    st     <= ST_IDLE;
                                    done_q <= 1'b1;
                                end
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    assign req_ready = (st == ST_IDLE);
    assign wr_ready  = wr_go;
    assign rd_valid  = rdv;
    assign rd_data   = rdd;
    assign done      = done_q;
    assign err       = err_q;
    assign cs_n      = !((st == ST_HDR) || (st == ST_DATA));

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
    parameter int LEN_W      = 16,
    parameter int PAGE_BYTES = 256,
    parameter int CS_GAP     = 2,
    parameter int SCK_HALF   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_op,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic             err,
    output logic             spi_cs_n,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    logic       eng_start;
    logic [7:0] eng_tx;
    logic       eng_done;
    logic [7:0] eng_rx;

    nor_seq_ctrl #(
        .LEN_W      (LEN_W),
        .PAGE_BYTES (PAGE_BYTES),
        .CS_GAP     (CS_GAP)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .wr_data   (wr_data),
        .rd_valid  (rd_valid),
        .rd_ready  (rd_ready),
        .rd_data   (rd_data),
        .done      (done),
        .err       (err),
        .cs_n      (spi_cs_n),
        .eng_start (eng_start),
        .eng_tx    (eng_tx),
        .eng_done  (eng_done),
        .eng_rx    (eng_rx)
    );

    nor_spi_engine #(
        .SCK_HALF (SCK_HALF)
    ) u_eng (
        .clk   (clk),
        .rst   (rst),
        .start (eng_start),
        .tx    (eng_tx),
        .done  (eng_done),
        .rx    (eng_rx),
        .sck   (spi_sck),
        .mosi  (spi_mosi),
        .miso  (spi_miso)
    );

endmodule

// File: rtl/nor_seq_checker.sv
module nor_seq_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       done,
    input logic       err,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic [7:0] rd_data,
    input logic       spi_cs_n,
    input logic       spi_sck,
    input logic       spi_mosi
);
    p_sck_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

    p_mosi_hold_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(spi_sck) && spi_sck) |-> $stable(spi_mosi));

    p_cs_gap_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |=> spi_cs_n);

    p_rd_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    p_reject_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        err |-> spi_cs_n);

    p_busy_blocks_r13: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |-> !req_ready);

    p_done_idle_r13: assert property (@(posedge clk) disable iff (rst)
        done |-> (req_ready && !err));

endmodule

bind nor_cmd_seq nor_seq_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .done      (done),
    .err       (err),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .spi_cs_n  (spi_cs_n),
    .spi_sck   (spi_sck),
    .spi_mosi  (spi_mosi)
);

// File: tb/tb_nor_cmd_seq.sv
`timescale 1ns/1ps
module tb_nor_cmd_seq;
    localparam int BUSY_POLLS = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = '0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [7:0]  wr_data = '0;
    logic        rd_valid;
    logic        rd_ready = 1'b0;
    logic [7:0]  rd_data;
    logic        done, err;
    logic        spi_cs_n, spi_sck, spi_mosi, spi_miso;

    always #2.5 clk = ~clk;

    nor_cmd_seq dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_len(req_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .done(done), .err(err),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int checks = 0;
    int fails  = 0;

    function automatic logic [7:0] id_b(int j);
        return 8'hE1 ^ j[7:0];
    endfunction
    function automatic logic [7:0] mem_b(logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction
    function automatic logic [7:0] prog_b(int k);
        return 8'((k * 37) + 11);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- flash device model ----------------
    bit          logging = 1'b0;
    int          tcount = 0;
    logic [7:0]  log_hdr [0:15][0:3];
    int          log_len [0:15];
    logic [31:0] log_hash [0:15];
    int          bytec = 0, bitc = 0, busy_left = 0;
    logic [7:0]  in_sh = '0, out_sh = '0, cmd = '0, next_out = '0;
    logic [23:0] maddr = '0;
    logic [31:0] hsh = '0;

    assign spi_miso = out_sh[7];

    always @(negedge spi_cs_n) if (logging) begin
        bytec = 0; bitc = 0; out_sh = '0; hsh = '0; cmd = '0;
    end

    always @(posedge spi_cs_n) if (logging) begin
        if (tcount < 16) begin
            log_len[tcount]  = bytec;
            log_hash[tcount] = hsh;
        end
        if (cmd == 8'h05 && busy_left > 0) busy_left--;
        if (cmd == 8'h02 || cmd == 8'hD8 || cmd == 8'hC7) busy_left = BUSY_POLLS;
        tcount++;
    end

    always @(posedge spi_sck) if (logging && !spi_cs_n) begin
        in_sh = {in_sh[6:0], spi_mosi};
        bitc++;
        if (bitc == 8) begin
            bitc = 0;
            if (bytec == 0) cmd = in_sh;
            if (bytec >= 1 && bytec <= 3) maddr = {maddr[15:0], in_sh};
            if (bytec < 4 && tcount < 16) log_hdr[tcount][bytec] = in_sh;
            if (bytec >= 4) hsh = (hsh * 33) ^ {24'h0, in_sh};
            bytec++;
            if (cmd == 8'h9F) next_out = id_b(bytec - 1);
            else if (cmd == 8'h03 && bytec >= 4) next_out = mem_b(maddr + 24'(bytec - 4));
            else if (cmd == 8'h05) next_out = (busy_left > 0) ? 8'h01 : 8'hFE;
            else next_out = 8'h00;
        end
    end

    always @(negedge spi_sck) if (logging && !spi_cs_n) begin
        if (bitc == 0) out_sh = next_out;
        else out_sh = {out_sh[6:0], 1'b0};
    end

    // ---------------- chip-select gap monitor (R3) ----------------
    int  hi_cnt = 0;
    bit  seen_low = 1'b0;
    always @(negedge clk) if (logging) begin
        if (spi_cs_n) hi_cnt++;
        else begin
            if (hi_cnt > 0 && seen_low) chk(hi_cnt >= 2, "R3 cs high gap", hi_cnt, 2);
            hi_cnt = 0;
            seen_low = 1'b1;
        end
    end

    // ---------------- request driver ----------------
    bit r_done, r_err, r_done_rdy;
    int r_rix, r_bad;

    task automatic run_op(input logic [2:0] op, input logic [23:0] a, input int len, input int rdpat);
        int  wix = 0, cyc = 0;
        bit  pend = 1'b1, req_acc = 1'b0, wacc = 0;
        logic [7:0] exp;
        tcount = 0; r_rix = 0; r_bad = 0; r_done = 0; r_err = 0; r_done_rdy = 0;
        @(negedge clk);
        req_op = op; req_addr = a; req_len = 16'(len); req_valid = 1'b1;
        while (!(r_done || r_err) && cyc < 60000) begin
            if (cyc > 0) @(negedge clk);
            cyc++;
            if (req_acc) begin req_valid = 1'b0; pend = 1'b0; req_acc = 1'b0; end
            if (wacc) wix++;
            wr_valid = (op == 3'd2) && (wix < len);
            wr_data  = prog_b(wix);
            rd_ready = (rdpat == 0) ? 1'b1 : ((cyc % rdpat) != 0);
            #1;
            if (done) begin r_done = 1'b1; r_done_rdy = req_ready; end
            if (err) r_err = 1'b1;
            req_acc = pend && req_ready;
            wacc = wr_valid && wr_ready;
            if (rd_valid && rd_ready) begin
                exp = (op == 3'd0) ? id_b(r_rix) : mem_b(a + 24'(r_rix));
                if (rd_data !== exp) r_bad++;
                r_rix++;
            end
        end
        req_valid = 1'b0;
        wr_valid  = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            rd_ready = 1'b1;
            #1;
            if (rd_valid) begin
                exp = (op == 3'd0) ? id_b(r_rix) : mem_b(a + 24'(r_rix));
                if (rd_data !== exp) r_bad++;
                r_rix++;
            end
        end
    endtask

    task automatic check_polls(input int first, input string tag);
        for (int t = first; t < first + BUSY_POLLS + 1; t++) begin
            chk(log_hdr[t][0] == 8'h05, {tag, " poll opcode"}, log_hdr[t][0], 8'h05);
            chk(log_len[t] == 2, {tag, " poll length"}, log_len[t], 2);
        end
    endtask

    task summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R13 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [23:0] a;
        logic [31:0] eh;
        int offs [4] = '{0, 16, 240, 255};
        int lens [5] = '{0, 1, 17, 256, 257};
        bit bad;

        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(spi_cs_n === 1'b1, "R1 cs_n", spi_cs_n, 1);
        chk(spi_sck === 1'b0, "R1 sck", spi_sck, 0);
        chk(req_ready === 1'b1, "R1 req_ready", req_ready, 1);
        chk({done, err, rd_valid} === 3'b000, "R1 flags", {done, err, rd_valid}, 0);
        logging = 1'b1;

        // R4 identify
        run_op(3'd0, 24'h0, 5, 0);
        chk(r_done && tcount == 1, "R4 ident txns", tcount, 1);
        chk(log_hdr[0][0] == 8'h9F, "R4 ident opcode", log_hdr[0][0], 8'h9F);
        chk(log_len[0] == 6, "R4 ident length", log_len[0], 6);
        chk(r_rix == 5 && r_bad == 0, "R4 ident bytes", r_rix * 256 + r_bad, 5 * 256);
        chk(r_done_rdy, "R13 ready with done", r_done_rdy, 1);

        // R5 / R6 read with back-pressure
        run_op(3'd1, 24'h1234F0, 20, 3);
        chk(r_done && tcount == 1, "R5 read txns", tcount, 1);
        chk({log_hdr[0][0], log_hdr[0][1], log_hdr[0][2], log_hdr[0][3]} == 32'h031234F0,
            "R5 read header", {log_hdr[0][0], log_hdr[0][1], log_hdr[0][2], log_hdr[0][3]}, 32'h031234F0);
        chk(log_len[0] == 24, "R5 read length", log_len[0], 24);
        chk(r_rix == 20 && r_bad == 0, "R6 read stream under stall", r_rix * 256 + r_bad, 20 * 256);

        run_op(3'd1, 24'hABCDEF, 7, 2);
        chk(r_rix == 7 && r_bad == 0, "R6 read stream alternate stall", r_rix * 256 + r_bad, 7 * 256);

        run_op(3'd1, 24'h000100, 0, 0);
        chk(r_done && log_len[0] == 4 && r_rix == 0, "R5 zero-length read", log_len[0], 4);

        // R7 / R9 / R11 program sweep
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 5; j++) begin
                a = 24'h0A0B00 | 24'(offs[i]);
                bad = (lens[j] == 0) || ((offs[i] + lens[j]) > 256);
                run_op(3'd2, a, lens[j], 0);
                if (bad) begin
                    chk(r_err && !r_done, "R11 reject flagged", {r_err, r_done}, 2'b10);
                    chk(tcount == 0, "R11 no transaction", tcount, 0);
                end else begin
                    eh = '0;
                    for (int k = 0; k < lens[j]; k++) eh = (eh * 33) ^ {24'h0, prog_b(k)};
                    chk(r_done && !r_err, "R9 program done", {r_done, r_err}, 2'b10);
                    chk(tcount == 3 + BUSY_POLLS, "R7 program txn count", tcount, 3 + BUSY_POLLS);
                    chk(log_hdr[0][0] == 8'h06 && log_len[0] == 1, "R7 write enable",
                        log_hdr[0][0], 8'h06);
                    chk({log_hdr[1][0], log_hdr[1][1], log_hdr[1][2], log_hdr[1][3]} == {8'h02, a},
                        "R7 program header", {log_hdr[1][0], log_hdr[1][1], log_hdr[1][2], log_hdr[1][3]},
                        {8'h02, a});
                    chk(log_len[1] == 4 + lens[j], "R7 program length", log_len[1], 4 + lens[j]);
                    chk(log_hash[1] == eh, "R7 program data", log_hash[1], eh);
                    check_polls(2, "R9");
                end
            end
        end

        // R8 erase 64 KB
        run_op(3'd3, 24'h3F0000, 0, 0);
        chk(r_done && tcount == 3 + BUSY_POLLS, "R8 erase64 txns", tcount, 3 + BUSY_POLLS);
        chk(log_hdr[0][0] == 8'h06 && log_len[0] == 1, "R8 erase64 write enable", log_hdr[0][0], 8'h06);
        chk({log_hdr[1][0], log_hdr[1][1], log_hdr[1][2], log_hdr[1][3]} == 32'hD83F0000,
            "R8 erase64 header", {log_hdr[1][0], log_hdr[1][1], log_hdr[1][2], log_hdr[1][3]}, 32'hD83F0000);
        chk(log_len[1] == 4, "R8 erase64 length", log_len[1], 4);
        check_polls(2, "R9 erase64");

        // R8 whole erase
        run_op(3'd4, 24'h0, 0, 0);
        chk(r_done && tcount == 3 + BUSY_POLLS, "R8 erase-all txns", tcount, 3 + BUSY_POLLS);
        chk(log_hdr[1][0] == 8'hC7 && log_len[1] == 1, "R8 erase-all opcode", log_hdr[1][0], 8'hC7);
        check_polls(2, "R9 erase-all");

        // R10 sleep / wake
        run_op(3'd5, 24'h0, 0, 0);
        chk(r_done && tcount == 1 && log_hdr[0][0] == 8'hB9 && log_len[0] == 1,
            "R10 sleep", log_hdr[0][0], 8'hB9);
        run_op(3'd6, 24'h0, 0, 0);
        chk(r_done && tcount == 1 && log_hdr[0][0] == 8'hAB && log_len[0] == 1,
            "R10 wake", log_hdr[0][0], 8'hAB);

        // R12 invalid code
        run_op(3'd7, 24'h0, 3, 0);
        chk(r_err && !r_done, "R12 invalid flagged", {r_err, r_done}, 2'b10);
        chk(tcount == 0, "R12 no transaction", tcount, 0);

        // back-to-back after a rejection (R13)
        run_op(3'd0, 24'h0, 2, 0);
        chk(r_done && r_rix == 2 && r_bad == 0, "R13 request after reject", r_rix, 2);

        summary();
        $finish;
    end

endmodule